// File: doc/BRIEF.md
# I2C Clock-Low Timeout Monitor

This block sits beside an I2C master sequencer and watches for a slave that stretches the clock for too long. Software sets an 8-bit limit. The limit becomes the top eight bits of a 12-bit down-counter, and the bottom four bits of the load are always zero. The counter loads when the sequencer reports a START. It then counts down once per period of an internal bus-rate tick. That tick keeps its programmed rate even while SCL is held low on the wire. Any moment in which the synchronized SCL is seen high reloads the counter, so only one unbroken low stretch is measured.

When the counter reaches zero, the block sets a sticky timeout status and a raw interrupt. It also keeps a request pending that tells the sequencer to issue a STOP as soon as both SCL and SDA are released. The status and the pending request are cleared by the sequencer's "STOP sent" pulse or by reset. The raw interrupt is cleared by a write-one-to-clear strobe. The synchronized SCL and SDA levels are also brought out for bus-monitor reads.

Top module: `i2c_clk_low_timeout`

## Requirements
- R1: With the bus-rate tick firing every cycle and SCL held low, the status and raw interrupt rise exactly (limit × 16) clock edges after the edge that captures `start_det`. For example, a limit of 0xDA gives 3488 edges.
- R2: The tick fires once every `rate_div`+1 clock cycles, and its divider restarts at START. Expiry therefore comes (limit × 16) × (`rate_div`+1) edges after START.
- R3: Every cycle in which the synchronized SCL is high reloads the counter. Two low stretches that are each shorter than the limit never cause expiry, even when their sum is longer.
- R4: A limit below 0x02 is invalid. The counter does not run and no expiry occurs.
- R5: `to_status` is sticky once set. Only a `stop_done` pulse or reset clears it.
- R6: `to_irq_raw` is set on expiry and cleared by `irq_clr`. It is not affected by `stop_done`.
- R7: `abort_stop` is 1 only while an expiry is pending and both synchronized SCL and SDA are high. `stop_done` withdraws it.
- R8: With no transaction in progress (before any START, or after `stop_done`), the counter holds and no expiry occurs.
- R9: `scl_mon` and `sda_mon` follow `scl_in` and `sda_in` with a latency of two clock edges.
- R10: After reset, `to_status`, `to_irq_raw` and `abort_stop` are 0, and `scl_mon` and `sda_mon` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| start_det | input | 1 | One-cycle pulse: sequencer issued a START |
| stop_done | input | 1 | One-cycle pulse: sequencer sent a STOP |
| limit_hi | input | 8 | Upper eight bits of the timeout count |
| rate_div | input | 8 | Bus-rate tick period minus one, in clock cycles |
| irq_clr | input | 1 | Write-one-to-clear strobe for the raw interrupt |
| to_status | output | 1 | Sticky timeout status |
| to_irq_raw | output | 1 | Raw timeout interrupt |
| abort_stop | output | 1 | Request to the sequencer: issue STOP now |
| scl_mon | output | 1 | Synchronized SCL level |
| sda_mon | output | 1 | Synchronized SDA level |

## Verification
A counter that loads the wrong value, or a divider that restarts at the wrong point, moves the rise of `to_status` away from the edge the limit predicts. The bench measures that edge exactly, so an error of a single tick shows at the port. A reload that misses an SCL-high cycle lets split low stretches add up, and that shows as a false expiry within the second stretch. A status or pending request that is cleared at the wrong time shows at `to_status` or `abort_stop` within one cycle of the wrong clear, or of the missing one.

// File: rtl/clto_pkg.sv
package clto_pkg;
    localparam int LIM_W   = 8;
    localparam int PAD_W   = 4;
    localparam int CNT_W   = LIM_W + PAD_W;
    localparam int DIV_W   = 8;
    localparam int LIM_MIN = 2;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lvl_t;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    typedef struct packed {
        logic status;
        logic irq;
        logic pend;
    } flag_state_t;

    function automatic logic [CNT_W-1:0] load_of(input logic [LIM_W-1:0] lim);
        return {lim, {PAD_W{1'b0}}};
    endfunction

    function automatic logic limit_ok(input logic [LIM_W-1:0] lim);
        return lim >= LIM_W'(LIM_MIN);
    endfunction
endpackage

// File: rtl/clto_sync.sv
module clto_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  clto_pkg::bus_lvl_t raw,
    output clto_pkg::bus_lvl_t synced
);
    import clto_pkg::*;

    bus_lvl_t chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '{scl: 1'b1, sda: 1'b1};
                else if (i == 0) chain[i] <= raw;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/clto_tick.sv
module clto_tick (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       restart,
    input  logic [clto_pkg::DIV_W-1:0] rate_div,
    output logic                       tick
);
    import clto_pkg::*;

    logic [DIV_W-1:0] div_cnt;

    assign tick = (div_cnt >= rate_div);

    always_ff @(posedge clk) begin
        if (rst || restart) div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else div_cnt <= div_cnt + 1'b1;
    end

    // R2
    tick_period_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> (div_cnt == '0));
endmodule

// File: rtl/clto_counter.sv
module clto_counter (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_det,
    input  logic                       stop_done,
    input  logic                       scl_high,
    input  logic                       tick,
    input  logic [clto_pkg::LIM_W-1:0] limit_hi,
    output logic                       expire
);
    import clto_pkg::*;

    cnt_state_t       st;
    logic [CNT_W-1:0] load_val;
    logic             cfg_ok;
    logic             run;

    assign load_val = load_of(limit_hi);
    assign cfg_ok   = limit_ok(limit_hi);
    assign run      = st.active && cfg_ok && !scl_high && !start_det;
    assign expire   = run && tick && (st.cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start_det) begin
            st.active <= 1'b1;
            st.cnt    <= load_val;
        end else if (stop_done) begin
            st.active <= 1'b0;
        end else if (st.active && (scl_high || !cfg_ok)) begin
            st.cnt <= load_val;
        end else if (run && tick && st.cnt != '0) begin
            st.cnt <= st.cnt - 1'b1;
        end
    end

    // R3
    reload_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && scl_high && !start_det && !stop_done) |=> (st.cnt == $past(load_val)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.active && !start_det) |=> $stable(st.cnt));

    // R4
    bad_cfg_no_expire_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |-> !expire);

    // R1
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (st.cnt == '0 && !start_det && !scl_high && cfg_ok) |=> (st.cnt == '0));
endmodule

// File: rtl/i2c_clk_low_timeout.sv
module i2c_clk_low_timeout (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       start_det,
    input  logic       stop_done,
    input  logic [7:0] limit_hi,
    input  logic [7:0] rate_div,
    input  logic       irq_clr,
    output logic       to_status,
    output logic       to_irq_raw,
    output logic       abort_stop,
    output logic       scl_mon,
    output logic       sda_mon
);
    import clto_pkg::*;

    bus_lvl_t    raw_lvl;
    bus_lvl_t    syn_lvl;
    logic        tick;
    logic        expire;
    flag_state_t fl;

    assign raw_lvl = '{scl: scl_in, sda: sda_in};

    clto_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_lvl),
        .synced (syn_lvl)
    );

    clto_tick u_tick (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_det),
        .rate_div (rate_div),
        .tick     (tick)
    );

    clto_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start_det (start_det),
        .stop_done (stop_done),
        .scl_high  (syn_lvl.scl),
        .tick      (tick),
        .limit_hi  (limit_hi),
        .expire    (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fl <= '0;
        end else begin
            if (expire) fl.status <= 1'b1;
            else if (stop_done) fl.status <= 1'b0;

            if (expire) fl.pend <= 1'b1;
            else if (stop_done) fl.pend <= 1'b0;

            if (expire) fl.irq <= 1'b1;
            else if (irq_clr) fl.irq <= 1'b0;
        end
    end

    assign to_status  = fl.status;
    assign to_irq_raw = fl.irq;
    assign abort_stop = fl.pend && syn_lvl.scl && syn_lvl.sda;
    assign scl_mon    = syn_lvl.scl;
    assign sda_mon    = syn_lvl.sda;

    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (to_status && !stop_done) |=> to_status);

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !expire) |=> !to_irq_raw);

    // R7
    abort_withdraw_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_done && !expire) |=> !abort_stop);

    // R9
    mon_latency_chk: assert property (@(posedge clk) disable iff (rst || $past(rst) || $past(rst, 2))
        scl_mon == $past(scl_in, 2));
endmodule

// File: tb/i2c_clk_low_timeout_bench.sv
module i2c_clk_low_timeout_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       scl_in, sda_in, start_det, stop_done, irq_clr;
    logic [7:0] limit_hi, rate_div;
    logic       to_status, to_irq_raw, abort_stop, scl_mon, sda_mon;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2c_clk_low_timeout u_i2c_clk_low_timeout (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .start_det(start_det), .stop_done(stop_done),
        .limit_hi(limit_hi), .rate_div(rate_div), .irq_clr(irq_clr),
        .to_status(to_status), .to_irq_raw(to_irq_raw), .abort_stop(abort_stop),
        .scl_mon(scl_mon), .sda_mon(sda_mon)
    );

    typedef struct packed {
        logic [7:0]  lim;
        logic [7:0]  div;
        logic [31:0] edges;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{lim: 8'h02, div: 8'd0, edges: 32'd32},
        '{lim: 8'h03, div: 8'd0, edges: 32'd48},
        '{lim: 8'h02, div: 8'd3, edges: 32'd128},
        '{lim: 8'h05, div: 8'd1, edges: 32'd160},
        '{lim: 8'hDA, div: 8'd0, edges: 32'd3488}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_done = 1'b1;
        @(negedge clk) stop_done = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; scl_in = 1'b1; sda_in = 1'b1; start_det = 1'b0;
        stop_done = 1'b0; irq_clr = 1'b0; limit_hi = 8'h02; rate_div = 8'd0;
        cycles(3);
        // R10 reset state
        chk("R10 status", to_status, 1'b0);
        chk("R10 irq", to_irq_raw, 1'b0);
        chk("R10 abort", abort_stop, 1'b0);
        chk("R10 scl_mon", scl_mon, 1'b1);
        chk("R10 sda_mon", sda_mon, 1'b1);
        @(negedge clk) rst = 1'b0;

        // R9 two-edge latency
        @(negedge clk) begin scl_in = 1'b0; sda_in = 1'b0; end
        @(negedge clk) chk("R9 scl_mon after 1 edge", scl_mon, 1'b1);
        @(negedge clk) begin
            chk("R9 scl_mon after 2 edges", scl_mon, 1'b0);
            chk("R9 sda_mon after 2 edges", sda_mon, 1'b0);
        end

        // R8 no transaction: SCL low, no START
        cycles(100);
        chk("R8 no start no expiry", to_status, 1'b0);

        // R1 R2 table walk
        foreach (VEC[i]) begin
            limit_hi = VEC[i].lim;
            rate_div = VEC[i].div;
            pulse_start();
            cycles(int'(VEC[i].edges) - 1);
            chk("R1 R2 not yet expired", to_status, 1'b0);
            chk("R1 R2 irq not yet", to_irq_raw, 1'b0);
            cycles(1);
            chk("R1 R2 expired on time", to_status, 1'b1);
            chk("R6 irq set on expiry", to_irq_raw, 1'b1);
            pulse_stop();
            chk("R5 status cleared by stop", to_status, 1'b0);
            chk("R6 irq unaffected by stop", to_irq_raw, 1'b1);
            @(negedge clk) irq_clr = 1'b1;
            @(negedge clk) irq_clr = 1'b0;
            chk("R6 irq cleared by w1c", to_irq_raw, 1'b0);
        end

        // R8 after stop: counter idle
        limit_hi = 8'h02; rate_div = 8'd0;
        cycles(80);
        chk("R8 idle after stop", to_status, 1'b0);

        // R4 invalid limits
        for (int v = 0; v < 2; v++) begin
            limit_hi = 8'(v);
            pulse_start();
            cycles(200);
            chk("R4 invalid limit no expiry", to_status, 1'b0);
            pulse_stop();
        end

        // R3 reload on SCL high: 20 low, high pulse, 20 low
        limit_hi = 8'h02;
        pulse_start();
        cycles(19);
        @(negedge clk) scl_in = 1'b1;
        @(negedge clk) scl_in = 1'b0;
        cycles(22);
        chk("R3 split low stretches no expiry", to_status, 1'b0);
        cycles(20);
        chk("R3 long continuous stretch expires", to_status, 1'b1);

        // R5 sticky while SCL released; R7 abort gating
        chk("R7 no abort while lines low", abort_stop, 1'b0);
        @(negedge clk) scl_in = 1'b1;
        cycles(5);
        chk("R5 status sticky after release", to_status, 1'b1);
        chk("R7 no abort while SDA low", abort_stop, 1'b0);
        @(negedge clk) sda_in = 1'b1;
        @(negedge clk) chk("R7 abort waits for sync", abort_stop, 1'b0);
        @(negedge clk) chk("R7 abort when both released", abort_stop, 1'b1);
        pulse_stop();
        chk("R7 abort withdrawn by stop", abort_stop, 1'b0);
        chk("R5 cleared by stop", to_status, 1'b0);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;

        // R10 reset clears flags mid-timeout
        @(negedge clk) begin scl_in = 1'b0; sda_in = 1'b0; end
        cycles(2);
        pulse_start();
        cycles(40);
        chk("R1 expired before reset", to_status, 1'b1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R10 status cleared by reset", to_status, 1'b0);
        chk("R10 irq cleared by reset", to_irq_raw, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule